// File: doc/BRIEF.md
# Tuner PLL Two-Wire Control Slave

This block is the serial control port of a tuner frequency synthesizer. It sits on an I2C bus as a slave, runs from an oversampled system clock, and cleans both bus lines with a synchronizer and a glitch filter before using them. It answers to one of four 7-bit addresses. The upper five bits of that address are a parameter and the lower two come from a strap input. It never stretches the clock and drives SDA only through an open-drain enable.

In a write telegram the data bytes are taken two at a time. The most significant bit of the first byte of each pair tells the block what the pair is. A zero means a 15-bit divider word. A one means a control byte, and the byte after it goes to either the band-switch register or the auxiliary register. A test field inside that control byte makes the choice. Nothing is written until the second byte of the pair has been acknowledged, so a pair that a stop or a repeated start cuts short leaves every register as it was.

In a read telegram the block sends a status byte. That byte holds a sticky power-on flag, a lock flag and a 3-bit converter value, and the block sends it again each time the master acknowledges. The power-on flag is set by reset and by a low-supply input. It clears when a read telegram ends.

The control state machine has these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the block acknowledges its address.
- `ST_WR_BYTE`: a data byte is being shifted in.
- `ST_WR_ACK`: the block acknowledges the data byte.
- `ST_RD_BYTE`: the status byte is being shifted out.
- `ST_RD_ACK`: the block samples the master's acknowledge.
- `ST_IGNORE`: the block waits for the bus to become free.

Its transitions are these:
- A start moves any state to `ST_ADDR`. A stop moves any state to `ST_IDLE`.
- From `ST_ADDR`, the SCL fall after the eighth bit goes to `ST_ADDR_ACK` if the address matches and to `ST_IGNORE` if it does not.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` when the R/W bit is 0 and to `ST_RD_BYTE` when it is 1.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits, and `ST_WR_ACK` goes back to `ST_WR_BYTE` after the ninth clock.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BYTE` when the master acknowledges and to `ST_IGNORE` when it does not.

Top module: `tpll_i2c_ctrl`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks after synchronization has no effect on decoding or on any register.
- R2: A start (SDA falls while SCL is high) begins address decoding from any state, including in the middle of a byte. After a stop (SDA rises while SCL is high), clock pulses that arrive without a new start are ignored.
- R3: The first byte is a 7-bit address sent MSB first, followed by R/W (0 = write, 1 = read). The own address is {5'b11000, addr_sel_i}. On a match the block pulls SDA low for the ninth clock. On a mismatch it leaves SDA released and changes no register.
- R4: All four strap values select their own address, and each responds to that address alone.
- R5: A data pair whose first byte has bit 7 = 0 loads div_o = {first[6:0], second}.
- R6: A data pair whose first byte has bit 7 = 1 loads ctrl_o with the first byte. The second byte goes to aux_o when bits [5:3] of that first byte equal 3'b011, and to band_o otherwise.
- R7: Pairs repeat through the telegram. The third byte, the fifth byte and so on each start a new pair, which is decoded by its own bit 7.
- R8: Registers change only after the second byte of a pair has been acknowledged. A single byte followed by a stop or a repeated start is discarded.
- R9: After a read address is acknowledged, the block sends status byte {por, lock_i, 3'b000, adc_i[2:0]} MSB first. It sends the byte again after each master acknowledge. After a master NACK it keeps SDA released until the next start.
- R10: The power-on flag is 1 after reset and is set while supply_low_i is high. A stop or a start that ends a read telegram clears it, unless supply_low_i is high at that moment.
- R11: The SDA output enable changes only while filtered SCL is low.
- R12: While rst_n is low, sda_oe_o is 0. Once reset is released, div_o, ctrl_o, band_o and aux_o are 0.
- R13: In a write telegram addressed to this block, every data byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 2 | Strap that picks the low two address bits |
| adc_i | input | 3 | Converter value reported in the status byte |
| lock_i | input | 1 | Synthesizer lock flag reported in the status byte |
| supply_low_i | input | 1 | Low-supply indication; sets the power-on flag |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| div_o | output | 15 | Divider word |
| ctrl_o | output | 8 | Control byte |
| band_o | output | 8 | Band-switch byte |
| aux_o | output | 8 | Auxiliary byte |

## Verification
Assertions check several properties on every cycle:
- the SDA enable stays put while SCL is high, and it is inactive during reset;
- a start always lands the machine in address decoding;
- a filtered line never moves while its synchronized input agrees with it;
- the divider changes only in the cycle after a strobe that completes a pair;
- the power-on flag follows the low-supply input and is cleared at the end of a read;
- SDA is released after a master NACK.

Only the bench's scenarios can show the decoding as a whole. That covers address matching across every strap, the divider and control values that land in the registers, the routing by test field, the repeated status bytes, the discarding of pairs cut short, and glitch rejection.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_t;

    localparam int          BYTE_BITS = 8;
    localparam int          ADC_W     = 3;
    localparam int          TEST_LSB  = 3;
    localparam int          TEST_W    = 3;
    localparam logic [2:0]  AUX_CODE  = 3'b011;

    function automatic logic [7:0] make_status(input logic por,
                                               input logic lock,
                                               input logic [ADC_W-1:0] adc);
        return {por, lock, 3'b000, adc};
    endfunction

endpackage

// File: rtl/tpll_line_filter.sv
module tpll_line_filter #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   clean_q;
    logic                   synced;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign clean_o = clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_q <= 1'b1;
            run_q   <= '0;
        end else if (synced == clean_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            clean_q <= synced;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (synced == clean_q) |=> $stable(clean_q));

endmodule

// File: rtl/tpll_bus_cond.sv
module tpll_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    assign start_o = scl_f_i & scl_q & sda_q & ~sda_f_i;
    assign stop_o  = scl_f_i & scl_q & ~sda_q & sda_f_i;
    assign rise_o  = scl_f_i & ~scl_q;
    assign fall_o  = ~scl_f_i & scl_q;

endmodule

// File: rtl/tpll_link_fsm.sv
module tpll_link_fsm
    import tpll_pkg::*;
#(
    parameter int                   STRAP_W = 2,
    parameter logic [6-STRAP_W:0]   ADDR_HI = 5'b11000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_sel_i,
    input  logic [7:0]         status_i,
    output logic               sda_oe_o,
    output logic               wr_stb_o,
    output logic [7:0]         wr_byte_o,
    output logic               pair_clr_o,
    output logic               rd_end_o
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    link_state_t state_q, state_d;
    logic [7:0]       sr_q;
    logic [7:0]       tx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mack_q;
    logic             rd_phase_q;
    logic [6:0]       own_addr;
    logic             byte_done;

    assign own_addr  = {ADDR_HI, addr_sel_i};
    assign byte_done = fall_i && (cnt_q == CNT_W'(BYTE_BITS));

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 state_d = (sr_q[7:1] == own_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (fall_i)
                                 state_d = sr_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (fall_i) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (fall_i && cnt_q == CNT_W'(BYTE_BITS - 1))
                                 state_d = ST_RD_ACK;
                ST_RD_ACK:   if (fall_i) state_d = mack_q ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q       <= '0;
            tx_q       <= '0;
            cnt_q      <= '0;
            mack_q     <= 1'b0;
            rd_phase_q <= 1'b0;
        end else if (start_i || stop_i) begin
            cnt_q      <= '0;
            rd_phase_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (rise_i) begin
                        sr_q  <= {sr_q[6:0], sda_i};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall_i) begin
                        cnt_q <= '0;
                        if (sr_q[0]) begin
                            tx_q       <= status_i;
                            rd_phase_q <= 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (fall_i) cnt_q <= '0;
                end
                ST_RD_BYTE: begin
                    if (fall_i) begin
                        tx_q  <= {tx_q[6:0], 1'b1};
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (rise_i) mack_q <= ~sda_i;
                    if (fall_i && mack_q) begin
                        tx_q  <= status_i;
                        cnt_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD_BYTE:             sda_oe_o = ~tx_q[7];
            default:                sda_oe_o = 1'b0;
        endcase
        wr_stb_o   = (state_q == ST_WR_ACK) && fall_i;
        wr_byte_o  = sr_q;
        pair_clr_o = start_i || stop_i;
        rd_end_o   = (start_i || stop_i) && rd_phase_q;
    end

    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_ADDR));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && fall_i && !mack_q && !start_i && !stop_i) |=> !sda_oe_o);

endmodule

// File: rtl/tpll_regbank.sv
module tpll_regbank
    import tpll_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [7:0]       wr_byte_i,
    input  logic             pair_clr_i,
    input  logic             rd_end_i,
    input  logic             supply_low_i,
    input  logic             lock_i,
    input  logic [ADC_W-1:0] adc_i,
    output logic [DIV_W-1:0] div_o,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       band_o,
    output logic [7:0]       aux_o,
    output logic [7:0]       status_o
);
    localparam int DIV_HI_W = DIV_W - 8;

    logic             half_q;
    logic [7:0]       first_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       ctrl_q, band_q, aux_q;
    logic             por_q;
    logic             to_aux;

    assign to_aux = (first_q[TEST_LSB +: TEST_W] == AUX_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            first_q <= '0;
            div_q   <= '0;
            ctrl_q  <= '0;
            band_q  <= '0;
            aux_q   <= '0;
        end else if (pair_clr_i) begin
            half_q <= 1'b0;
        end else if (wr_stb_i) begin
            if (!half_q) begin
                first_q <= wr_byte_i;
                half_q  <= 1'b1;
            end else begin
                half_q <= 1'b0;
                if (!first_q[7]) begin
                    div_q <= {first_q[DIV_HI_W-1:0], wr_byte_i};
                end else begin
                    ctrl_q <= first_q;
                    if (to_aux) aux_q  <= wr_byte_i;
                    else        band_q <= wr_byte_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            por_q <= 1'b1;
        else if (supply_low_i) por_q <= 1'b1;
        else if (rd_end_i)     por_q <= 1'b0;
    end

    assign div_o    = div_q;
    assign ctrl_o   = ctrl_q;
    assign band_o   = band_q;
    assign aux_o    = aux_q;
    assign status_o = make_status(por_q, lock_i, adc_i);

    // R8
    div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> $past(wr_stb_i && half_q && !pair_clr_i));

    // R10
    por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> por_q);

    // R10
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end_i && !supply_low_i) |=> !por_q);

endmodule

// File: rtl/tpll_i2c_ctrl.sv
module tpll_i2c_ctrl
    import tpll_pkg::*;
#(
    parameter int                   FILT_LEN = 4,
    parameter int                   STRAP_W  = 2,
    parameter logic [6-STRAP_W:0]   ADDR_HI  = 5'b11000,
    parameter int                   DIV_W    = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] addr_sel_i,
    input  logic [ADC_W-1:0]   adc_i,
    input  logic               lock_i,
    input  logic               supply_low_i,
    output logic               sda_oe_o,
    output logic [DIV_W-1:0]   div_o,
    output logic [7:0]         ctrl_o,
    output logic [7:0]         band_o,
    output logic [7:0]         aux_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic scl_f, sda_f;
    logic start_p, stop_p, rise_p, fall_p;
    logic wr_stb, pair_clr, rd_end;
    logic [7:0] wr_byte, status;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = clean_lines[0];
    assign sda_f     = clean_lines[1];

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tpll_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[g]),
            .clean_o (clean_lines[g])
        );
    end

    tpll_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f_i (scl_f),
        .sda_f_i (sda_f),
        .start_o (start_p),
        .stop_o  (stop_p),
        .rise_o  (rise_p),
        .fall_o  (fall_p)
    );

    tpll_link_fsm #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .rise_i     (rise_p),
        .fall_i     (fall_p),
        .sda_i      (sda_f),
        .addr_sel_i (addr_sel_i),
        .status_i   (status),
        .sda_oe_o   (sda_oe_o),
        .wr_stb_o   (wr_stb),
        .wr_byte_o  (wr_byte),
        .pair_clr_o (pair_clr),
        .rd_end_o   (rd_end)
    );

    tpll_regbank #(.DIV_W(DIV_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb_i     (wr_stb),
        .wr_byte_i    (wr_byte),
        .pair_clr_i   (pair_clr),
        .rd_end_i     (rd_end),
        .supply_low_i (supply_low_i),
        .lock_i       (lock_i),
        .adc_i        (adc_i),
        .div_o        (div_o),
        .ctrl_o       (ctrl_o),
        .band_o       (band_o),
        .aux_o        (aux_o),
        .status_o     (status)
    );

    // R11
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe_o));

    // R12
    always @(negedge clk) begin
        if (!rst_n) begin
            rst_oe_chk: assert (!sda_oe_o);
        end
    end

endmodule

// File: tb/tpll_i2c_ctrl_test.sv
module tpll_i2c_ctrl_test;

    localparam int H = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, m_scl, m_low, lock, slow;
    logic [1:0]  sel;
    logic [2:0]  adc;
    logic        sda_oe;
    logic [14:0] div;
    logic [7:0]  ctrl, band, aux;
    wire         sda_line = ~(m_low | sda_oe);

    int checks = 0;
    int fails  = 0;
    logic [14:0] e_div;
    logic [7:0]  e_ctrl, e_band, e_aux;
    logic        e_por;

    tpll_i2c_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel_i(sel), .adc_i(adc), .lock_i(lock), .supply_low_i(slow),
        .sda_oe_o(sda_oe), .div_o(div), .ctrl_o(ctrl), .band_o(band), .aux_o(aux)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic b_start();
        m_low = 1'b0; m_scl = 1'b1; tick(H);
        m_low = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic b_restart();
        m_low = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_low = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic b_stop();
        m_low = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_low = 1'b0; tick(H);
    endtask

    task automatic wbit(input logic b);
        m_low = ~b; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic rbit(output logic b);
        m_low = 1'b0; tick(H);
        m_scl = 1'b1; tick(H/2);
        b = sda_line; tick(H/2);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic send_glitchy(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~v[i]; tick(H/2);
            m_scl = 1'b1; tick(2); m_scl = 1'b0;
            tick(H/2);
            m_scl = 1'b1; tick(H/2);
            if (v[i]) begin m_low = 1'b1; tick(2); m_low = 1'b0; end
            tick(H/2);
            m_scl = 1'b0; tick(4);
        end
        rbit(a);
        ack = ~a;
    endtask

    task automatic recv(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) rbit(v[i]);
        wbit(~mack);
    endtask

    task automatic wr_pair(input logic [6:0] a, input logic [7:0] b1, input logic [7:0] b2,
                           output logic aa, output logic d1, output logic d2);
        b_start();
        send({a, 1'b0}, aa);
        send(b1, d1);
        send(b2, d2);
        b_stop();
    endtask

    function automatic logic [7:0] st(input logic por, input logic lk, input logic [2:0] ad);
        return {por, lk, 3'b000, ad};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic aa, d1, d2, dummy;
        logic [7:0] rb;
        logic [6:0] me;
        rst_n = 1'b0; m_scl = 1'b1; m_low = 1'b0;
        sel = 2'd0; adc = 3'd0; lock = 1'b0; slow = 1'b0;
        tick(3);
        chk("R12 oe during reset", sda_oe, 0);
        tick(3);
        rst_n = 1'b1;
        tick(4);
        chk("R12 div reset", div, 0);
        chk("R12 ctrl reset", ctrl, 0);
        chk("R12 band reset", band, 0);
        chk("R12 aux reset", aux, 0);
        e_div = '0; e_ctrl = '0; e_band = '0; e_aux = '0; e_por = 1'b1;

        // R3 R4: strap sweep against every candidate address
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s); tick(2);
            for (int a = 0; a < 4; a++) begin
                logic [14:0] v;
                v = 15'(s * 1000 + a * 77 + 5);
                wr_pair({5'b11000, 2'(a)}, {1'b0, v[14:8]}, v[7:0], aa, d1, d2);
                if (a == s) e_div = v;
                chk("R3 R4 address ack", aa, (a == s) ? 1 : 0);
                chk("R3 R4 divider after addressed write", div, e_div);
            end
        end
        sel = 2'd2; me = 7'b1100010;

        // R5 R13: divider values
        for (int k = 0; k < 8; k++) begin
            logic [14:0] v;
            v = (k == 7) ? 15'h7fff : 15'((k * 4663 + k) & 32'h7fff);
            wr_pair(me, {1'b0, v[14:8]}, v[7:0], aa, d1, d2);
            e_div = v;
            chk("R5 divider word", div, e_div);
            chk("R13 data acks", {d1, d2}, 2'b11);
        end

        // R6: control pair routed by test field
        for (int t = 0; t < 8; t++) begin
            logic [7:0] c, b2;
            c  = 8'h80 | 8'(t << 3) | 8'(7 - t);
            b2 = 8'(8'h11 * t) ^ 8'h5a;
            wr_pair(me, c, b2, aa, d1, d2);
            e_ctrl = c;
            if (t == 3) e_aux = b2; else e_band = b2;
            chk("R6 control byte", ctrl, e_ctrl);
            chk("R6 band byte", band, e_band);
            chk("R6 aux byte", aux, e_aux);
        end
        chk("R6 divider untouched", div, e_div);

        // R7: two pairs in one telegram
        b_start();
        send({me, 1'b0}, aa);
        send(8'h2a, d1); send(8'hc3, d2);
        send(8'hc5, d1); send(8'h77, d2);
        b_stop();
        e_div = 15'h2ac3; e_ctrl = 8'hc5; e_band = 8'h77;
        chk("R7 divider from first pair", div, e_div);
        chk("R7 control from second pair", ctrl, e_ctrl);
        chk("R7 band from second pair", band, e_band);

        // R8: incomplete pair at stop
        b_start();
        send({me, 1'b0}, aa);
        send(8'h11, d1);
        b_stop();
        chk("R8 single byte then stop", div, e_div);
        // R8: incomplete pair at repeated start
        b_start();
        send({me, 1'b0}, aa);
        send(8'hb9, d1);
        b_restart();
        send({me, 1'b0}, aa);
        send(8'h05, d1); send(8'h06, d2);
        b_stop();
        e_div = 15'h0506;
        chk("R8 ctrl after cut pair", ctrl, e_ctrl);
        chk("R8 divider after restart", div, e_div);

        // R2: restart in the middle of an address byte
        b_start();
        wbit(1'b0); wbit(1'b1); wbit(1'b1);
        b_restart();
        send({me, 1'b0}, aa);
        send(8'h33, d1); send(8'h44, d2);
        b_stop();
        e_div = 15'h3344;
        chk("R2 restart mid address", div, e_div);
        // R2: clocks after stop without start are ignored
        for (int i = 7; i >= 0; i--) wbit(me[i > 0 ? i - 1 : 0]);
        wbit(1'b1);
        for (int i = 7; i >= 0; i--) wbit(1'(8'h12 >> i));
        wbit(1'b1);
        for (int i = 7; i >= 0; i--) wbit(1'(8'h34 >> i));
        wbit(1'b1);
        chk("R2 no decode after stop", div, e_div);
        chk("R2 oe idle after stop", sda_oe, 0);

        // R1: glitches on both lines
        b_start();
        send_glitchy({me, 1'b0}, aa);
        send_glitchy(8'h5d, d1);
        send_glitchy(8'hb6, d2);
        b_stop();
        e_div = 15'h5db6;
        chk("R1 glitch filtered address ack", aa, 1);
        chk("R1 glitch filtered divider", div, e_div);

        // R9 R10: read three status bytes
        adc = 3'd5; lock = 1'b1;
        b_start();
        send({me, 1'b1}, aa);
        chk("R9 read address ack", aa, 1);
        for (int n = 0; n < 3; n++) begin
            recv(rb, n < 2);
            chk("R9 R10 status byte", rb, st(e_por, lock, adc));
        end
        chk("R9 released after nack", sda_oe, 0);
        tick(H);
        chk("R9 still released", sda_oe, 0);
        b_stop();
        e_por = 1'b0;

        adc = 3'd2; lock = 1'b0;
        b_start();
        send({me, 1'b1}, aa);
        recv(rb, 1'b0);
        b_stop();
        chk("R10 flag cleared after read", rb, st(e_por, lock, adc));

        slow = 1'b1; tick(3); slow = 1'b0; tick(3);
        e_por = 1'b1;
        b_start();
        send({me, 1'b1}, aa);
        recv(rb, 1'b1);
        recv(rb, 1'b0);
        b_stop();
        chk("R10 flag set by low supply", rb, st(e_por, lock, adc));
        e_por = 1'b0;
        b_start();
        send({me, 1'b1}, aa);
        recv(rb, 1'b0);
        b_stop();
        chk("R10 flag cleared again", rb, st(e_por, lock, adc));

        // R3: mismatched read address
        b_start();
        send({7'b1100001, 1'b1}, aa);
        rbit(dummy);
        b_stop();
        chk("R3 no ack foreign read", aa, 0);
        chk("R3 no drive foreign read", dummy, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule